// File: doc/BRIEF.md
# Cascaded Three-Stage Digital Noise Shaper

This block turns a signed input word into a short stream of small multi-level codes whose running average tracks the input. It does this with three first-order accumulator loops in cascade. The first loop accumulates the input. The second loop accumulates the residue that the first loop leaves behind. The third loop accumulates the residue of the second. Each loop on its own is a first-order modulator, so each is stable for any input.

The three one-bit carries are recombined in digital logic. The first carry is passed through as it is. The second carry goes through one delay-and-subtract stage. The third carry goes through two such stages in series. In the sum, the error of the first loop is cancelled by the second path and the error of the second loop is cancelled by the third. What remains is the third loop's error with third-order high-pass shaping.

A typical use is as the digital core of a fractional divider or of a multi-level DAC driver. A new sample is taken on every clock in which the sample enable is high, and one output code follows on the next clock.

Top module: `mash3_shaper`

## Requirements
- R1: The signed input x of IN_W bits is mapped to the unsigned value u = x + 2^(IN_W-1), which is x with its top bit inverted. The first accumulator adds u modulo M = 2^(IN_W) on each enabled sample, and its carry out is that stage's output bit.
- R2: On the same sample, the second accumulator adds the first accumulator's new residue, and the third accumulator adds the second's new residue. The carries of these two stages are their output bits.
- R3: The code for sample n is c1[n] + (c2[n] - c2[n-1]) + (c3[n] - 2*c3[n-1] + c3[n-2]). It is registered and appears on out_code in the clock after the enabling edge. As an example with IN_W = 8 and x = 0 held after reset, the first three valid codes are -1, +1, 0. With x = -64 held after reset, they are -1, +2, -2.
- R4: out_code is a two's-complement 4-bit value, and every valid code lies in the range -3 to +4.
- R5: For a constant input, the sum S of L consecutive valid codes satisfies |M*S - L*u| < 4*M.
- R6: A synchronous reset clears all accumulators, carry histories and the fill count. It also drives out_valid to 0 and out_code to 0.
- R7: out_valid is high only in the clock after an enabled sample. It stays low for the first two enabled samples after reset, while the carry history fills.
- R8: While smp_en is low, no state advances: out_valid is 0, out_code keeps its value, and the code sequence continues unchanged when sampling resumes.
- R9: The most negative input (u = 0) gives a code of 0 on every valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Takes one input sample on this clock |
| smp_in | input | IN_W | Signed input word |
| out_valid | output | 1 | out_code carries a new valid code |
| out_code | output | 4 | Signed shaped output code |

## Verification
The bench builds the block with IN_W = 8, so M = 256. At that width a run of 4096 samples per input value gives a tight bound on the average, and hand-worked sequences from reset fit in a few codes. The input table covers both ends of the input scale, mid-scale, and several fractions whose carry patterns do not repeat with a short period. A short run with idle gaps between samples shows that the code sequence is unchanged by pauses in the enable.

// File: rtl/mash3_pkg.sv
package mash3_pkg;

  typedef logic signed [2:0] term_t;
  typedef logic signed [3:0] code_t;

  // delay-and-subtract applied once to a carry stream
  function automatic term_t first_diff(input logic now_b, input logic prev_b);
    term_t r;
    r = 3'sd0;
    if (now_b)  r = r + 3'sd1;
    if (prev_b) r = r - 3'sd1;
    return r;
  endfunction

  // delay-and-subtract applied twice
  function automatic term_t second_diff(input logic now_b, input logic d1_b, input logic d2_b);
    term_t r;
    r = 3'sd0;
    if (now_b) r = r + 3'sd1;
    if (d1_b)  r = r - 3'sd2;
    if (d2_b)  r = r + 3'sd1;
    return r;
  endfunction

  function automatic code_t combine(input logic c1, input term_t t2, input term_t t3);
    code_t r;
    r = code_t'(t2) + code_t'(t3);
    if (c1) r = r + 4'sd1;
    return r;
  endfunction

endpackage

// File: rtl/mash3_stage.sv
module mash3_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic         carry,
  output logic [W-1:0] resid
);

  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, din};
  end

  assign carry = sum[W];
  assign resid = sum[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= resid;
  end

endmodule

// File: rtl/mash3_diff.sv
module mash3_diff
  import mash3_pkg::*;
#(
  parameter int ORDER = 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  bit_in,
  output term_t term
);

  if (ORDER == 1) begin : g_first
    logic d1_q;
    always_ff @(posedge clk) begin
      if (rst)     d1_q <= 1'b0;
      else if (en) d1_q <= bit_in;
    end
    assign term = first_diff(bit_in, d1_q);
  end else begin : g_second
    logic d1_q, d2_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        d1_q <= 1'b0;
        d2_q <= 1'b0;
      end else if (en) begin
        d1_q <= bit_in;
        d2_q <= d1_q;
      end
    end
    assign term = second_diff(bit_in, d1_q, d2_q);
  end

endmodule

// File: rtl/mash3_fill.sv
module mash3_fill #(
  parameter int FILL_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic primed
);

  localparam int CW = $clog2(FILL_LEN + 1);

  logic [CW-1:0] cnt_q;

  assign primed = (cnt_q == CW'(FILL_LEN));

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (en && !primed)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/mash3_shaper.sv
module mash3_shaper
  import mash3_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_en,
  input  logic signed [IN_W-1:0] smp_in,
  output logic                   out_valid,
  output logic signed [3:0]      out_code
);

  localparam int STAGES   = 3;
  localparam int FILL_LEN = STAGES - 1;

  logic [IN_W-1:0]   chain [0:STAGES];
  logic [STAGES-1:0] carry;
  term_t             terms [1:STAGES-1];
  code_t             code_next;
  logic              primed;
  logic              unused_tail;

  // offset-binary view of the signed sample
  function automatic logic [IN_W-1:0] to_offset(input logic signed [IN_W-1:0] v);
    return {~v[IN_W-1], v[IN_W-2:0]};
  endfunction

  assign chain[0]    = to_offset(smp_in);
  assign unused_tail = ^chain[STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    mash3_stage #(.W(IN_W)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .en    (smp_en),
      .din   (chain[i]),
      .carry (carry[i]),
      .resid (chain[i+1])
    );
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_diff
    mash3_diff #(.ORDER(k)) u_diff (
      .clk    (clk),
      .rst    (rst),
      .en     (smp_en),
      .bit_in (carry[k]),
      .term   (terms[k])
    );
  end

  mash3_fill #(.FILL_LEN(FILL_LEN)) u_fill (
    .clk    (clk),
    .rst    (rst),
    .en     (smp_en),
    .primed (primed)
  );

  assign code_next = combine(carry[0], terms[1], terms[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= smp_en && primed;
      if (smp_en) out_code <= code_next;
    end
  end

endmodule

// File: rtl/mash3_checker.sv
module mash3_checker
  import mash3_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              smp_en,
  input logic              out_valid,
  input logic signed [3:0] out_code,
  input term_t             mid_term,
  input term_t             fine_term
);

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code >= -4'sd3 && out_code <= 4'sd4)); // R4

  AST_MID_TERM: assert property (@(posedge clk) disable iff (rst)
    (mid_term >= -3'sd1 && mid_term <= 3'sd1)); // R3

  AST_FINE_TERM: assert property (@(posedge clk) disable iff (rst)
    (fine_term >= -3'sd2 && fine_term <= 3'sd2)); // R3

  AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(smp_en)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> (!out_valid && $stable(out_code))); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_code == 4'sd0)); // R6

endmodule

bind mash3_shaper mash3_checker u_mash3_checker (
  .clk       (clk),
  .rst       (rst),
  .smp_en    (smp_en),
  .out_valid (out_valid),
  .out_code  (out_code),
  .mid_term  (terms[1]),
  .fine_term (terms[2])
);

// File: tb/test_mash3_shaper.sv
module test_mash3_shaper;

  localparam int IN_W  = 8;
  localparam int MODV  = 1 << IN_W;
  localparam int RUN_L = 4096;
  localparam int VEC_N = 7;
  // stimulus: signed input, expected offset value u = x + M/2
  localparam int VEC_X [VEC_N] = '{-128, -100, -1, 0, 37, 85, 127};
  localparam int VEC_U [VEC_N] = '{0, 28, 127, 128, 165, 213, 255};

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   smp_en = 1'b0;
  logic signed [IN_W-1:0] smp_in = '0;
  logic                   out_valid;
  logic signed [3:0]      out_code;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  mash3_shaper #(.IN_W(IN_W)) i_mash3_shaper (
    .clk       (clk),
    .rst       (rst),
    .smp_en    (smp_en),
    .smp_in    (smp_in),
    .out_valid (out_valid),
    .out_code  (out_code)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge; results of that sample are visible at the next falling edge
  task automatic step(input bit en, input int x);
    smp_en = en;
    smp_in = IN_W'(x);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    smp_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // run x from reset and compare the first three valid codes
  task automatic exact_seq(input int x, input int e0, input int e1, input int e2, input string req);
    int got [3];
    int k;
    k = 0;
    do_reset();
    for (int s = 0; s < 5; s++) begin
      step(1'b1, x);
      if (out_valid && k < 3) begin
        got[k] = int'(out_code);
        k++;
      end
    end
    check(got[0] == e0, req, got[0], e0);
    check(got[1] == e1, req, got[1], e1);
    check(got[2] == e2, req, got[2], e2);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int got [3];
    int k;
    logic signed [3:0] held;
    bool_ok_t: begin end
    @(negedge clk);
    @(negedge clk);
    // R6: reset state
    check(out_valid == 1'b0, "R6 valid in reset", out_valid, 0);
    check(out_code == 4'sd0, "R6 code in reset", out_code, 0);
    rst = 1'b0;

    // R7: no valid for first two enabled samples
    do_reset();
    step(1'b1, 0);
    check(out_valid == 1'b0, "R7 first sample", out_valid, 0);
    step(1'b1, 0);
    check(out_valid == 1'b0, "R7 second sample", out_valid, 0);
    step(1'b1, 0);
    check(out_valid == 1'b1, "R7 third sample", out_valid, 1);

    // R1 R2 R3: hand-worked sequences
    exact_seq(0, -1, 1, 0, "R3 x=0");
    exact_seq(-64, -1, 2, -2, "R2 x=-64");

    // R8: idle gaps must not change the sequence
    do_reset();
    k = 0;
    for (int s = 0; s < 5; s++) begin
      step(1'b1, 0);
      if (out_valid && k < 3) begin
        got[k] = int'(out_code);
        k++;
      end
      held = out_code;
      step(1'b0, 55);
      check(out_valid == 1'b0 && out_code == held, "R8 idle hold", out_code, held);
    end
    check(got[0] == -1 && got[1] == 1 && got[2] == 0, "R8 sequence after gaps",
          got[0] * 100 + got[1] * 10 + got[2], -100 + 10 + 0);

    // R5 R4 R9: average over long constant runs
    for (int v = 0; v < VEC_N; v++) begin
      longint sum;
      longint cnt;
      longint err;
      int bad_range;
      int nonzero;
      sum = 0; cnt = 0; bad_range = 0; nonzero = 0;
      do_reset();
      for (int s = 0; s < RUN_L + 2; s++) begin
        step(1'b1, VEC_X[v]);
        if (out_valid) begin
          sum += longint'(out_code);
          cnt++;
          if (out_code < -4'sd3 || out_code > 4'sd4) bad_range++;
          if (out_code != 4'sd0) nonzero++;
        end
      end
      err = longint'(MODV) * sum - cnt * longint'(VEC_U[v]);
      if (err < 0) err = -err;
      check(err < 4 * MODV, "R5 mean", longint'(MODV) * sum, cnt * longint'(VEC_U[v]));
      check(bad_range == 0, "R4 range", bad_range, 0);
      if (VEC_U[v] == 0) check(nonzero == 0, "R9 zero-scale", nonzero, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule